// File: doc/BRIEF.md
# Interleaved Dual-NAND Stream Writer

This block records an unbroken byte stream from an acquisition front end into two raw NAND flash devices that share one 8-bit bus. Whole pages alternate between the two devices. While one device runs its internal page program, which takes far longer than loading a page, the next page is loaded into the other device. This hides the program time. Each device owns one page of on-chip buffer, so storage stays at two pages in total.

The memory is erased and scanned for bad blocks before capture. No erase is ever issued while recording. A logical block index is presented on `lblk_idx`, and a lookup outside the block returns the physical block on `pblk`. Logical indices are consumed strictly in ascending order. Recording stops for good once `blk_count` logical blocks are filled in both devices.

Input back-pressure rules:
- A byte moves only on a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` falls when the buffer that is next to be filled is still waiting to be written.
- `in_ready` stays low for good once the full capacity has been accepted.

Top module: `nand_stream_writer`

## Requirements
- R1: A byte is accepted only when `in_valid` and `in_ready` are both high at a clock edge. Bytes are stored in arrival order. `in_ready` is low while both page buffers are full. Exactly `blk_count*PPB*2*PAGE_BYTES` bytes are accepted, and no more.
- R2: Programmed page n, counting from 0, goes to device n mod 2, with device 0 first. During every bus strobe exactly one of `nand_ce_n[1:0]` is low. Bit 0 low selects device 0.
- R3: A page write consists of these bus cycles, in this order:
  - command 0x80 (`nand_cle` high);
  - five address cycles (`nand_ale` high): column low 0x00, column high 0x00, then row bits [7:0], [15:8] and [23:16];
  - `PAGE_BYTES` data cycles carrying the page bytes in arrival order;
  - command 0x10.
- R4: The row address is `pblk*PPB + page`. Within each device, `page` counts 0 to PPB-1. After device 1 finishes page PPB-1, `lblk_idx` increments and `page` returns to 0. `pblk` is sampled at the 0x80 cycle.
- R5: No 0x80 or 0x70 command is sent to a device while its `nand_rb_n` bit is low. The next page is loaded into one device while the other device is still busy.
- R6: After each program, and before that device is used again or recording ends, the block sends 0x70 and then one read cycle. If bit 0 of the status byte is set, `err` goes high and stays high until reset.
- R7: The only commands ever sent are 0x80, 0x10 and 0x70. In particular, no erase is sent.
- R8: `done` rises after all `blk_count*PPB*2` pages are programmed and their status has been read. After that there is no further bus activity, `in_ready` stays low and `done` stays high.
- R9: Reset (`rst_n` low, synchronous) gives the following state:
  - `in_ready` high and `done`, `err` low;
  - `nand_ce_n` = 2'b11, and `nand_we_n`, `nand_re_n` high.
- R10: Each bus cycle is one clock with the strobe low followed by one clock with it high. The address, data and control pins are held through both clocks. `nand_we_n` and `nand_re_n` are never low together. Read data is sampled at the end of the low clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte can be taken |
| in_data | input | 8 | Stream byte |
| blk_count | input | LIDX_W | Number of logical blocks to fill |
| lblk_idx | output | LIDX_W | Logical block index sent to the lookup |
| pblk | input | PBLK_W | Physical block returned by the lookup |
| nand_ce_n | output | 2 | Device selects, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus data driven by the block |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus data from the devices |
| nand_rb_n | input | 2 | Ready/busy per device, low while busy |
| err | output | 1 | Sticky program-failure flag |
| done | output | 1 | Recording complete |

## Verification
The critical coincidence is a stream byte that completes one page buffer landing on the same edge that the sequencer releases the other buffer after its last data cycle. Two full-speed flags then change in one cycle, and `in_ready` must come out right from both. The bench provokes this by holding `in_valid` high while the simulated devices stay busy longer than a page transfer takes, so stalls and releases collide repeatedly. A second run feeds a gappy input instead. The scoreboard then judges the outcome: every programmed page must carry exactly the queued bytes, and a single dropped or duplicated byte shows up as a mismatch. A second overlap is also covered: a page load into one device while the other is busy. The device model flags any command sent to a busy device and counts these overlaps.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_DATA, OP_READ} op_e;
  localparam logic [7:0] CMD_LOAD = 8'h80;
  localparam logic [7:0] CMD_PROG = 8'h10;
  localparam logic [7:0] CMD_STAT = 8'h70;
endpackage

// File: rtl/nsw_page_buf.sv
module nsw_page_buf #(
  parameter int PAGE_BYTES = 2048,
  parameter int TP_W = 23
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [7:0]                   in_data,
  input  logic [TP_W-1:0]              total,
  input  logic                         rd_sel,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [7:0]                   rd_data,
  input  logic                         rel,
  output logic [1:0]                   full
);
  localparam int DI_W = $clog2(PAGE_BYTES);

  logic [7:0]      mem [2][PAGE_BYTES];
  logic            wsel;
  logic [DI_W-1:0] wptr;
  logic [TP_W-1:0] acc;
  logic            wr;

  assign in_ready = !full[wsel] && (acc != total);
  assign wr       = in_valid && in_ready;
  assign rd_data  = mem[rd_sel][rd_idx];

  always_ff @(posedge clk) begin
    if (wr) mem[wsel][wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel <= 1'b0;
      wptr <= '0;
      acc  <= '0;
      full <= 2'b00;
    end else begin
      if (rel) full[rd_sel] <= 1'b0;
      if (wr) begin
        if (wptr == DI_W'(PAGE_BYTES - 1)) begin
          full[wsel] <= 1'b1;
          wsel       <= ~wsel;
          wptr       <= '0;
          acc        <= acc + 1'b1;
        end else begin
          wptr <= wptr + 1'b1;
        end
      end
    end
  end

  // R1: a stalled offer leaves the fill position untouched
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(wptr));
  // R1: only a buffer holding a complete page can be released
  p_rel_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> full[rd_sel]);
endmodule

// File: rtl/nsw_bus_phy.sv
module nsw_bus_phy import nsw_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  op_e        kind,
  input  logic [7:0] wbyte,
  input  logic       chip,
  output logic       op_done,
  output logic [7:0] rdata,
  output logic [1:0] ce_n,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  input  logic [7:0] io_in
);
  typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} pst_e;
  pst_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= P_IDLE;
      op_done <= 1'b0;
      rdata   <= '0;
      ce_n    <= 2'b11;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      io_out  <= '0;
      io_oe   <= 1'b0;
    end else begin
      case (st)
        P_IDLE: begin
          op_done <= 1'b0;
          if (req) begin
            ce_n   <= chip ? 2'b01 : 2'b10;
            cle    <= (kind == OP_CMD);
            ale    <= (kind == OP_ADDR);
            io_out <= wbyte;
            io_oe  <= (kind != OP_READ);
            if (kind == OP_READ) re_n <= 1'b0;
            else                 we_n <= 1'b0;
            st <= P_LOW;
          end
        end
        P_LOW: begin
          we_n <= 1'b1;
          re_n <= 1'b1;
          if (!re_n) rdata <= io_in;
          st <= P_HIGH;
        end
        default: begin
          op_done <= 1'b1;
          st      <= P_IDLE;
        end
      endcase
    end
  end

  // R10: write strobe is a single low clock
  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> we_n);
  // R10: never both strobes at once
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R7: only load, program and status commands reach the bus
  p_cmd_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && cle) |-> (io_out == CMD_LOAD || io_out == CMD_PROG || io_out == CMD_STAT));
endmodule

// File: rtl/nsw_seq.sv
module nsw_seq import nsw_pkg::*; #(
  parameter int PAGE_BYTES = 2048,
  parameter int PPB = 64,
  parameter int LIDX_W = 16,
  parameter int PBLK_W = 16,
  parameter int TP_W = 23
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TP_W-1:0]              total,
  output logic [LIDX_W-1:0]            lblk_idx,
  input  logic [PBLK_W-1:0]            pblk,
  input  logic [1:0]                   buf_full,
  output logic                         cur,
  output logic [$clog2(PAGE_BYTES)-1:0] didx,
  input  logic [7:0]                   buf_byte,
  output logic                         rel,
  input  logic [1:0]                   rb_n,
  output logic                         phy_req,
  output op_e                          phy_kind,
  output logic [7:0]                   phy_byte,
  input  logic                         phy_done,
  input  logic [7:0]                   phy_rdata,
  output logic                         err,
  output logic                         done
);
  localparam int DI_W  = $clog2(PAGE_BYTES);
  localparam int PG_W  = $clog2(PPB);
  localparam int ROW_W = 24;

  typedef enum logic [3:0] {S_IDLE, S_POLL, S_STCMD, S_STRD, S_PCMD,
                            S_ADDR, S_DATA, S_CONF, S_DONE} sst_e;
  sst_e              state;
  logic              wait_op;
  logic [1:0]        pend;
  logic [2:0]        acnt;
  logic [PG_W-1:0]   page_cnt;
  logic [LIDX_W-1:0] lidx;
  logic [TP_W-1:0]   issued;
  logic [1:0]        guard;
  logic [ROW_W-1:0]  row_q;
  logic [1:0]        rb_s1, rb_s;
  logic [6:0]        unused_stat;

  assign unused_stat = phy_rdata[7:1];
  assign lblk_idx    = lidx;

  for (genvar g = 0; g < 2; g++) begin : g_rbsync
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rb_s1[g] <= 1'b0;
        rb_s[g]  <= 1'b0;
      end else begin
        rb_s1[g] <= rb_n[g];
        rb_s[g]  <= rb_s1[g];
      end
    end
  end

  always_comb begin
    phy_req  = !wait_op;
    phy_kind = OP_CMD;
    phy_byte = 8'h00;
    case (state)
      S_STCMD: phy_byte = CMD_STAT;
      S_STRD:  phy_kind = OP_READ;
      S_PCMD:  phy_byte = CMD_LOAD;
      S_ADDR: begin
        phy_kind = OP_ADDR;
        case (acnt)
          3'd2:    phy_byte = row_q[7:0];
          3'd3:    phy_byte = row_q[15:8];
          3'd4:    phy_byte = row_q[23:16];
          default: phy_byte = 8'h00;
        endcase
      end
      S_DATA: begin
        phy_kind = OP_DATA;
        phy_byte = buf_byte;
      end
      S_CONF:  phy_byte = CMD_PROG;
      default: phy_req = 1'b0;
    endcase
  end

  assign rel = phy_done && (state == S_DATA) && (didx == DI_W'(PAGE_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wait_op  <= 1'b0;
      cur      <= 1'b0;
      pend     <= 2'b00;
      err      <= 1'b0;
      done     <= 1'b0;
      acnt     <= '0;
      didx     <= '0;
      page_cnt <= '0;
      lidx     <= '0;
      issued   <= '0;
      guard    <= '0;
      row_q    <= '0;
    end else begin
      if (guard != 2'd0) guard <= guard - 1'b1;
      if (phy_req) wait_op <= 1'b1;
      if (phy_done) wait_op <= 1'b0;
      case (state)
        S_IDLE: begin
          if (issued == total) begin
            if (pend[cur]) state <= S_POLL;
            else if (pend[~cur]) begin
              cur   <= ~cur;
              state <= S_POLL;
            end else begin
              done  <= 1'b1;
              state <= S_DONE;
            end
          end else if (buf_full[cur]) begin
            state <= pend[cur] ? S_POLL : S_PCMD;
          end
        end
        S_POLL: if (guard == 2'd0 && rb_s[cur]) state <= S_STCMD;
        S_STCMD: if (phy_done) state <= S_STRD;
        S_STRD: if (phy_done) begin
          err       <= err | phy_rdata[0];
          pend[cur] <= 1'b0;
          state     <= S_IDLE;
        end
        S_PCMD: if (phy_done) begin
          acnt  <= '0;
          row_q <= ROW_W'({pblk, page_cnt});
          state <= S_ADDR;
        end
        S_ADDR: if (phy_done) begin
          if (acnt == 3'd4) begin
            didx  <= '0;
            state <= S_DATA;
          end else acnt <= acnt + 1'b1;
        end
        S_DATA: if (phy_done) begin
          if (didx == DI_W'(PAGE_BYTES - 1)) state <= S_CONF;
          else didx <= didx + 1'b1;
        end
        S_CONF: if (phy_done) begin
          pend[cur] <= 1'b1;
          guard     <= 2'd3;
          cur       <= ~cur;
          issued    <= issued + 1'b1;
          if (cur) begin
            if (page_cnt == PG_W'(PPB - 1)) begin
              page_cnt <= '0;
              lidx     <= lidx + 1'b1;
            end else page_cnt <= page_cnt + 1'b1;
          end
          state <= S_IDLE;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  // R5: a page load starts only on a device reporting ready
  p_no_load_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_kind == OP_CMD && phy_byte == CMD_LOAD) |-> rb_s[cur]);
  // R6: failure flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/nand_stream_writer.sv
module nand_stream_writer import nsw_pkg::*; #(
  parameter int PAGE_BYTES = 2048,
  parameter int PPB = 64,
  parameter int LIDX_W = 16,
  parameter int PBLK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [LIDX_W-1:0] blk_count,
  output logic [LIDX_W-1:0] lblk_idx,
  input  logic [PBLK_W-1:0] pblk,
  output logic [1:0]        nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic [1:0]        nand_rb_n,
  output logic              err,
  output logic              done
);
  localparam int DI_W = $clog2(PAGE_BYTES);
  localparam int PG_W = $clog2(PPB);
  localparam int TP_W = LIDX_W + PG_W + 1;

  logic [TP_W-1:0] total;
  logic [1:0]      buf_full;
  logic            cur, rel, phy_req, phy_done;
  logic [DI_W-1:0] didx;
  logic [7:0]      buf_byte, phy_byte, phy_rdata;
  op_e             phy_kind;

  assign total = TP_W'(blk_count) << (PG_W + 1);

  nsw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .TP_W(TP_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .total(total), .rd_sel(cur), .rd_idx(didx),
    .rd_data(buf_byte), .rel(rel), .full(buf_full));

  nsw_seq #(.PAGE_BYTES(PAGE_BYTES), .PPB(PPB), .LIDX_W(LIDX_W),
            .PBLK_W(PBLK_W), .TP_W(TP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .total(total), .lblk_idx(lblk_idx),
    .pblk(pblk), .buf_full(buf_full), .cur(cur), .didx(didx),
    .buf_byte(buf_byte), .rel(rel), .rb_n(nand_rb_n), .phy_req(phy_req),
    .phy_kind(phy_kind), .phy_byte(phy_byte), .phy_done(phy_done),
    .phy_rdata(phy_rdata), .err(err), .done(done));

  nsw_bus_phy u_phy (
    .clk(clk), .rst_n(rst_n), .req(phy_req), .kind(phy_kind),
    .wbyte(phy_byte), .chip(cur), .op_done(phy_done), .rdata(phy_rdata),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .io_out(nand_io_out), .io_oe(nand_io_oe),
    .io_in(nand_io_in));

  // R8: once finished the input stays closed and done holds
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: tb/nand_stream_writer_test.sv
module nand_stream_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 8;
  localparam int PPB  = 4;
  localparam int BUSY = 90;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic [15:0] blk_count = 16'd3;
  logic [15:0] lblk_idx;
  logic [15:0] pblk;
  logic [1:0] nand_ce_n;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out, nand_io_in;
  logic [1:0] nand_rb_n;
  logic err, done;

  int busy_cnt [2];
  logic [7:0] stat [2];
  bit need_stat [2];
  bit stat_armed [2];
  int acnt [2];
  int dcnt [2];
  logic [7:0] addr_b [2][5];
  logic [7:0] data_b [2][PAGE];
  logic [7:0] exp_q [$];
  int pg_seen, overlap, we_events, fail_page, accepted, stalls, cyc;
  int n_checks, n_errs;
  bit wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pblk = 16'(lblk_idx * 3 + 5);
  assign nand_io_in = stat[nand_ce_n[0]];
  assign nand_rb_n = {busy_cnt[1] == 0, busy_cnt[0] == 0};

  nand_stream_writer #(.PAGE_BYTES(PAGE), .PPB(PPB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .blk_count(blk_count), .lblk_idx(lblk_idx),
    .pblk(pblk), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n), .err(err), .done(done));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Device model and scoreboard monitor
  task automatic nand_model();
    bit we_p = 1'b1, re_p = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        for (int c = 0; c < 2; c++) begin
          busy_cnt[c] = 0; stat[c] = 8'h40; need_stat[c] = 0;
          stat_armed[c] = 0; acnt[c] = 0; dcnt[c] = 0;
        end
        pg_seen = 0; overlap = 0; we_events = 0;
        we_p = 1'b1; re_p = 1'b1;
        continue;
      end
      for (int c = 0; c < 2; c++) if (busy_cnt[c] != 0) busy_cnt[c]--;
      if (!we_p && nand_we_n) begin
        int c;
        c = int'(nand_ce_n[0]);
        we_events++;
        chk(nand_ce_n == 2'b10 || nand_ce_n == 2'b01, "R2 one select", nand_ce_n, 1);
        if (nand_cle) begin
          case (nand_io_out)
            8'h80: begin
              chk(busy_cnt[c] == 0, "R5 load while busy", busy_cnt[c], 0);
              chk(!need_stat[c], "R6 status skipped", need_stat[c], 0);
              chk(c == pg_seen % 2, "R2 device order", c, pg_seen % 2);
              if (busy_cnt[1-c] != 0) overlap++;
              acnt[c] = 0; dcnt[c] = 0;
            end
            8'h10: begin
              int k, row, bad;
              logic [7:0] e;
              k = pg_seen / 2;
              row = ((k / PPB) * 3 + 5) * PPB + (k % PPB);
              chk(acnt[c] == 5 && dcnt[c] == PAGE, "R3 cycle counts", acnt[c]*100 + dcnt[c], 500 + PAGE);
              chk(addr_b[c][0] == 0 && addr_b[c][1] == 0 && addr_b[c][2] == row[7:0] &&
                  addr_b[c][3] == row[15:8] && addr_b[c][4] == row[23:16], "R4 row address",
                  {addr_b[c][4], addr_b[c][3], addr_b[c][2]}, row);
              bad = 0;
              for (int i = 0; i < PAGE; i++) begin
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                if (data_b[c][i] !== e) begin
                  if (bad == 0) $display("FAIL R3 data page %0d byte %0d actual=%0d expected=%0d",
                                         pg_seen, i, data_b[c][i], e);
                  bad++;
                end
              end
              n_checks++;
              if (bad != 0) n_errs++;
              if (pg_seen == fail_page) chk(err == 1'b0, "R6 err early", err, 0);
              stat[c] = (pg_seen == fail_page) ? 8'h41 : 8'h40;
              need_stat[c] = 1; busy_cnt[c] = BUSY;
              pg_seen++;
            end
            8'h70: begin
              chk(busy_cnt[c] == 0, "R5 status while busy", busy_cnt[c], 0);
              stat_armed[c] = 1;
            end
            default: chk(0, "R7 illegal command", nand_io_out, 8'h80);
          endcase
        end else if (nand_ale) begin
          if (acnt[c] < 5) addr_b[c][acnt[c]] = nand_io_out;
          acnt[c]++;
        end else begin
          if (dcnt[c] < PAGE) data_b[c][dcnt[c]] = nand_io_out;
          dcnt[c]++;
        end
      end
      if (!re_p && nand_re_n) begin
        int c;
        c = int'(nand_ce_n[0]);
        chk(stat_armed[c], "R6 read without 0x70", stat_armed[c], 1);
        stat_armed[c] = 0; need_stat[c] = 0;
      end
      we_p = nand_we_n; re_p = nand_re_n;
    end
  endtask

  // Driver: pushes each accepted byte into the scoreboard queue
  task automatic drive(input int mode);
    bit rdy_prev = 1'b0;
    int k = 0;
    accepted = 0; stalls = 0; in_valid = 1'b0;
    while (!done && !wd) begin
      bit took;
      @(negedge clk);
      took = in_valid && rdy_prev;
      if (took) begin
        exp_q.push_back(in_data);
        accepted++; k++;
      end
      if (in_valid && !in_ready) stalls++;
      if (took || !in_valid) begin
        in_valid = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        in_data  = (mode == 0) ? 8'(k + 1) : 8'((k * 7 + 3) ^ 8'h5a);
      end
      rdy_prev = in_ready;
    end
    in_valid = 1'b1;
  endtask

  task automatic reset_dut(input logic [15:0] blocks, input int fpage);
    in_valid = 1'b0; rst_n = 1'b0; blk_count = blocks; fail_page = fpage;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_errs = 0; wd = 0; cyc = 0; fail_page = -1;
    for (int c = 0; c < 2; c++) begin busy_cnt[c] = 0; stat[c] = 8'h40; end
    fork
      nand_model();
      forever begin
        @(posedge clk);
        cyc++;
        if (cyc > WD_LIMIT) wd = 1;
      end
    join_none

    // Run 1: full-speed input, failing status on last page
    reset_dut(16'd3, 23);
    chk(in_ready && !done && !err, "R9 reset flags", {in_ready, done, err}, 3'b100);
    chk(nand_ce_n == 2'b11 && nand_we_n && nand_re_n, "R9 reset pins",
        {nand_ce_n, nand_we_n, nand_re_n}, 4'b1111);
    drive(0);
    chk(!wd, "R8 watchdog run1", wd, 0);
    chk(done, "R8 done run1", done, 1);
    chk(pg_seen == 24, "R8 page total run1", pg_seen, 24);
    chk(accepted == 24 * PAGE, "R1 bytes accepted run1", accepted, 24 * PAGE);
    chk(exp_q.size() == 0, "R1 queue drained run1", exp_q.size(), 0);
    chk(stalls > 0, "R1 back-pressure seen", stalls, 1);
    chk(overlap > 0, "R5 program overlap", overlap, 1);
    chk(err, "R6 failure flagged", err, 1);
    chk(!need_stat[0] && !need_stat[1], "R6 final status read", need_stat[0] + need_stat[1], 0);
    begin
      int ev;
      ev = we_events;
      repeat (30) @(negedge clk);
      chk(we_events == ev, "R8 bus quiet after done", we_events, ev);
      chk(!in_ready && done, "R8 closed after done", {in_ready, done}, 2'b01);
      chk(err, "R6 err sticky", err, 1);
    end

    // Run 2: gappy input, no failure, fewer blocks
    reset_dut(16'd2, -1);
    chk(!err && !done && in_ready, "R9 reset clears err", {err, done, in_ready}, 3'b001);
    drive(1);
    chk(!wd, "R8 watchdog run2", wd, 0);
    chk(pg_seen == 16, "R8 page total run2", pg_seen, 16);
    chk(accepted == 16 * PAGE, "R1 bytes accepted run2", accepted, 16 * PAGE);
    chk(exp_q.size() == 0, "R1 queue drained run2", exp_q.size(), 0);
    chk(!err, "R6 no false failure", err, 0);
    chk(overlap > 0, "R5 overlap run2", overlap, 1);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule